// File: doc/BRIEF.md
# Serial ADC Control-Word Front End

This block is the device-side digital front end of a multichannel serial converter. While chip-select is low it watches the serial data input for a start bit. It then takes in a seven-bit control word that selects the channel, the input coding, the input configuration and the power mode. Once the word is complete it runs a fixed-length conversion handshake. A status strobe is raised for one serial clock, and then a twelve-bit result is shifted out, most significant bit first. The result is ten data bits followed by two sub-LSB bits. The analog path is not modelled: a parallel result input stands in for the conversion result and is sampled when the conversion starts.

All serial timing is taken from edges of the serial clock, which is sampled by a faster system clock. The block also tracks the power mode. A software power mode chosen in the control word takes effect only when the conversion ends, and any new start bit returns the block to full power. An active-low shutdown input overrides all of this at once and aborts any frame in flight. After reset the block ignores start bits for a programmable settling interval.

Top module: `serial_adc_frontend`

## Requirements
- R1: While chip-select is low, the block is ready and shutdown is high, the first serial-clock rising edge with the data input high is taken as the start bit. Rising edges with the data input low before it have no effect.
- R2: The seven rising edges after the start bit capture, in order, channel bits 2, 1 and 0, the unipolar flag (1 = unipolar), the single-ended flag (1 = single-ended), then power bits 1 and 0. The channel, flag and power-field outputs change only on the seventh of these edges.
- R3: Counting the falling edge after the start bit as falling edge 1, the result input is sampled on falling edge 8. Falling edges 9 through 20 then drive result bits 11 down to 0 on the data output, where bits [11:2] are the ten data bits and bits [1:0] are the two sub-LSB bits.
- R4: The data output is 0 whenever it is not presenting a result bit, including every frame before the first conversion has ended.
- R5: The output-enable of the data output and the output-enable of the strobe are both low while chip-select is high.
- R6: The status strobe is high from falling edge 8 to falling edge 9 and low at all other times.
- R7: Power field encoding: 11 = full power, 10 and 01 = the two standby modes, 00 = full power-down. The power field of a frame takes effect on falling edge 9, when the conversion ends, and not before.
- R8: A start bit received in any power mode sets the power output to 11 immediately.
- R9: While shutdown is low, any frame is aborted, the strobe and data output stay low, start bits are ignored and the power output reads 00. After shutdown is released the power output reads 11.
- R10: After reset the power output is 11, the channel and flag outputs are 0, the strobe is low, and `ready_o` stays low for SETTLE_CYCLES system clocks. Start bits are ignored while `ready_o` is low.
- R11: Raising chip-select mid-frame aborts the frame. The power output and the control outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on) |
| cs_n | input | 1 | Active-low chip-select |
| sclk | input | 1 | Serial clock, sampled by clk |
| sdi | input | 1 | Serial data input |
| shdn_n | input | 1 | Active-low hardware shutdown |
| result_i | input | 12 | Stand-in conversion result: [11:2] data, [1:0] sub-LSB bits |
| sdo_o | output | 1 | Serial data output value |
| sdo_oe_o | output | 1 | Drive enable for the data output (low = high impedance) |
| sstrb_o | output | 1 | Status strobe value |
| sstrb_oe_o | output | 1 | Drive enable for the strobe (low = high impedance) |
| chan_o | output | 3 | Committed channel select |
| unipolar_o | output | 1 | Committed coding flag |
| single_o | output | 1 | Committed input-configuration flag |
| pwr_o | output | 2 | Effective power mode |
| ready_o | output | 1 | Settling interval after reset has elapsed |

## Verification
A wrong frame state shows up within one serial half-period. Either the strobe rises on the wrong falling edge, or the data output presents a result bit early or late, so every later bit of that frame miscompares. A wrong control-word shift order or a wrong commit point shows on the channel, flag and power outputs on the seventh control edge. It also corrupts the power mode applied one and a half serial clocks later. A power mode applied at the wrong time, or a missed override by shutdown or by a start bit, appears on `pwr_o` in the half-period where the bench expects the change.

// File: rtl/adc_if_pkg.sv
package adc_if_pkg;

    localparam int unsigned CTRL_BITS = 7;
    localparam int unsigned RES_BITS  = 12;
    localparam int unsigned CNT_W     = $clog2(RES_BITS);

    localparam logic [1:0] PWR_FULL = 2'b11;
    localparam logic [1:0] PWR_OFF  = 2'b00;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_WAIT,
        ST_STRB,
        ST_XMIT
    } frame_st_e;

    typedef struct packed {
        logic [2:0] chan;
        logic       uni;
        logic       sgl;
        logic [1:0] pd;
    } ctrl_t;

endpackage

// File: rtl/adc_if_edge.sv
module adc_if_edge #(
    parameter int unsigned SETTLE_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    output logic rise_o,
    output logic fall_o,
    output logic ready_o
);
    localparam int unsigned CW = (SETTLE_CYCLES < 1) ? 1 : $clog2(SETTLE_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYCLES);

    typedef struct packed {
        logic          sclk;
        logic [CW-1:0] por;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sclk = sclk_i;
        if (st_q.por != LIMIT) begin
            st_d.por = st_q.por + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o  = sclk_i & ~st_q.sclk;
    assign fall_o  = ~sclk_i & st_q.sclk;
    assign ready_o = (st_q.por == LIMIT);

    // R10: once settled, the block stays settled until the next reset
    p_ready_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> ready_o);

endmodule

// File: rtl/adc_if_frame.sv
module adc_if_frame
    import adc_if_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cs_n,
    input  logic  sdi,
    input  logic  shdn_n,
    input  logic  ready_i,
    input  logic  rise_i,
    input  logic  fall_i,
    output ctrl_t ctrl_o,
    output logic [1:0] pwr_o,
    output logic  strobe_o,
    output logic  load_o,
    output logic  show_o,
    output logic  shift_o,
    output logic  clear_o
);
    typedef struct packed {
        frame_st_e             st;
        logic [CNT_W-1:0]      cnt;
        logic [CTRL_BITS-2:0]  sh;
        ctrl_t                 ctrl;
        logic [1:0]            pwr;
    } frame_t;

    frame_t fr_d, fr_q;

    always_comb begin
        fr_d    = fr_q;
        load_o  = 1'b0;
        show_o  = 1'b0;
        shift_o = 1'b0;
        clear_o = 1'b0;
        if (!shdn_n) begin
            fr_d.st  = ST_IDLE;
            fr_d.cnt = '0;
            fr_d.pwr = PWR_FULL;
            clear_o  = 1'b1;
        end else if (cs_n) begin
            fr_d.st  = ST_IDLE;
            fr_d.cnt = '0;
            clear_o  = 1'b1;
        end else begin
            unique case (fr_q.st)
                ST_IDLE: begin
                    if (rise_i && sdi && ready_i) begin
                        fr_d.st  = ST_CTRL;
                        fr_d.cnt = '0;
                        fr_d.pwr = PWR_FULL;
                    end
                end
                ST_CTRL: begin
                    if (rise_i) begin
                        fr_d.sh  = {fr_q.sh[CTRL_BITS-3:0], sdi};
                        fr_d.cnt = fr_q.cnt + CNT_W'(1);
                        if (fr_q.cnt == CNT_W'(CTRL_BITS - 1)) begin
                            fr_d.ctrl = ctrl_t'({fr_q.sh, sdi});
                            fr_d.st   = ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (fall_i) begin
                        fr_d.st = ST_STRB;
                        load_o  = 1'b1;
                    end
                end
                ST_STRB: begin
                    if (fall_i) begin
                        fr_d.st  = ST_XMIT;
                        fr_d.cnt = '0;
                        fr_d.pwr = fr_q.ctrl.pd;
                        show_o   = 1'b1;
                    end
                end
                ST_XMIT: begin
                    if (fall_i) begin
                        if (fr_q.cnt == CNT_W'(RES_BITS - 1)) begin
                            fr_d.st = ST_IDLE;
                            clear_o = 1'b1;
                        end else begin
                            fr_d.cnt = fr_q.cnt + CNT_W'(1);
                            shift_o  = 1'b1;
                        end
                    end
                end
                default: fr_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q      <= '0;
            fr_q.st   <= ST_IDLE;
            fr_q.pwr  <= PWR_FULL;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign ctrl_o   = fr_q.ctrl;
    assign pwr_o    = shdn_n ? fr_q.pwr : PWR_OFF;
    assign strobe_o = (fr_q.st == ST_STRB);

    // R2: committed control fields move only when the control word completes
    p_ctrl_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fr_q.ctrl) |-> $past(fr_q.st) == ST_CTRL);

    // R7: a software power mode lands only at conversion end; otherwise only full power
    p_pwr_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fr_q.pwr) |-> ($past(fr_q.st) == ST_STRB) || (fr_q.pwr == PWR_FULL));

    // R9: shutdown forces the frame back to idle
    p_shdn_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n |=> fr_q.st == ST_IDLE);

    // R10: no frame can begin before the settling interval ends
    p_por_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_i |-> fr_q.st == ST_IDLE);

    // R6: the strobe only ever drops into result transfer or an abort
    p_strobe_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe_o) |-> (fr_q.st == ST_XMIT) || (fr_q.st == ST_IDLE));

    // R3: result transfer never runs past the last bit
    p_xmit_cnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.st == ST_XMIT) |-> fr_q.cnt < CNT_W'(RES_BITS));

endmodule

// File: rtl/adc_if_shift.sv
module adc_if_shift
    import adc_if_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic                show_i,
    input  logic                shift_i,
    input  logic                clear_i,
    input  logic [RES_BITS-1:0] result_i,
    output logic                sdo_o
);
    typedef struct packed {
        logic [RES_BITS-1:0] shreg;
        logic                valid;
    } shift_t;

    shift_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (clear_i) begin
            sh_d.valid = 1'b0;
        end else if (load_i) begin
            sh_d.shreg = result_i;
            sh_d.valid = 1'b0;
        end else if (show_i) begin
            sh_d.valid = 1'b1;
        end else if (shift_i) begin
            sh_d.shreg = {sh_q.shreg[RES_BITS-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign sdo_o = sh_q.valid & sh_q.shreg[RES_BITS-1];

    // R3: load, present and shift requests from the sequencer never overlap
    p_ctl_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({load_i, show_i, shift_i}) <= 1);

    // R3: shifting only happens while a result is being presented
    p_shift_after_show_r3: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |-> sh_q.valid);

endmodule

// File: rtl/serial_adc_frontend.sv
module serial_adc_frontend
    import adc_if_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                sclk,
    input  logic                sdi,
    input  logic                shdn_n,
    input  logic [11:0]         result_i,
    output logic                sdo_o,
    output logic                sdo_oe_o,
    output logic                sstrb_o,
    output logic                sstrb_oe_o,
    output logic [2:0]          chan_o,
    output logic                unipolar_o,
    output logic                single_o,
    output logic [1:0]          pwr_o,
    output logic                ready_o
);
    logic  rise, fall, ready;
    logic  load, show, shift, clear, strobe;
    ctrl_t ctrl;

    adc_if_edge #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_i  (sclk),
        .rise_o  (rise),
        .fall_o  (fall),
        .ready_o (ready)
    );

    adc_if_frame u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sdi      (sdi),
        .shdn_n   (shdn_n),
        .ready_i  (ready),
        .rise_i   (rise),
        .fall_i   (fall),
        .ctrl_o   (ctrl),
        .pwr_o    (pwr_o),
        .strobe_o (strobe),
        .load_o   (load),
        .show_o   (show),
        .shift_o  (shift),
        .clear_o  (clear)
    );

    adc_if_shift u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .show_i   (show),
        .shift_i  (shift),
        .clear_i  (clear),
        .result_i (result_i),
        .sdo_o    (sdo_o)
    );

    assign sdo_oe_o   = ~cs_n;
    assign sstrb_oe_o = ~cs_n;
    assign sstrb_o    = strobe;
    assign chan_o     = ctrl.chan;
    assign unipolar_o = ctrl.uni;
    assign single_o   = ctrl.sgl;
    assign ready_o    = ready;

endmodule

// File: tb/serial_adc_frontend_tb_top.sv
module serial_adc_frontend_tb_top;

    localparam int SETTLE = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        shdn_n = 1'b1;
    logic [11:0] result_i = '0;
    logic        sdo_o, sdo_oe_o, sstrb_o, sstrb_oe_o, unipolar_o, single_o, ready_o;
    logic [2:0]  chan_o;
    logic [1:0]  pwr_o;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    // behavioural reference state
    int         m_rise = 0;
    int         m_fall = 0;
    logic [6:0] m_bits = '0;
    logic [2:0] m_chan = '0;
    logic       m_uni = 1'b0;
    logic       m_sgl = 1'b0;
    logic [1:0] m_pd = 2'b11;
    logic [1:0] m_pwr = 2'b11;
    logic [11:0] m_res = '0;
    logic       m_sdo = 1'b0;
    logic       m_strb = 1'b0;
    logic       m_ready = 1'b0;

    always #5 clk = ~clk;

    serial_adc_frontend #(.SETTLE_CYCLES(SETTLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .shdn_n(shdn_n), .result_i(result_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
        .sstrb_o(sstrb_o), .sstrb_oe_o(sstrb_oe_o), .chan_o(chan_o),
        .unipolar_o(unipolar_o), .single_o(single_o), .pwr_o(pwr_o), .ready_o(ready_o)
    );

    task automatic chk(input string tag, input string name, input logic [11:0] act, input logic [11:0] exp);
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h (t=%0t)", tag, name, act, exp, $time);
        end
    endtask

    task automatic compare();
        vectors++;
        chk("R3", "sdo", 12'(sdo_o), 12'(m_sdo));
        chk("R5", "sdo_oe", 12'(sdo_oe_o), 12'(!cs_n));
        chk("R5", "sstrb_oe", 12'(sstrb_oe_o), 12'(!cs_n));
        chk("R6", "sstrb", 12'(sstrb_o), 12'(m_strb));
        chk("R2", "chan", 12'(chan_o), 12'(m_chan));
        chk("R2", "unipolar", 12'(unipolar_o), 12'(m_uni));
        chk("R2", "single", 12'(single_o), 12'(m_sgl));
        chk("R7", "pwr", 12'(pwr_o), 12'(shdn_n ? m_pwr : 2'b00));
        chk("R10", "ready", 12'(ready_o), 12'(m_ready));
    endtask

    task automatic settle_and_compare();
        repeat (3) @(negedge clk);
        compare();
    endtask

    function automatic bit model_live();
        return !cs_n && shdn_n && m_ready;
    endfunction

    task automatic model_abort();
        m_rise = 0;
        m_fall = 0;
        m_strb = 1'b0;
        m_sdo  = 1'b0;
    endtask

    task automatic sedge(input logic lvl, input logic din);
        @(negedge clk);
        sdi  = din;
        sclk = lvl;
        if (lvl && model_live()) begin
            if (m_rise == 0) begin
                if (din) begin               // R1 start bit, R8 back to full power
                    m_rise = 1;
                    m_fall = 0;
                    m_pwr  = 2'b11;
                end
            end else if (m_rise < 8) begin
                m_bits = {m_bits[5:0], din};
                m_rise++;
                if (m_rise == 8) begin       // R2 commit on the seventh bit
                    m_chan = m_bits[6:4];
                    m_uni  = m_bits[3];
                    m_sgl  = m_bits[2];
                    m_pd   = m_bits[1:0];
                end
            end
        end else if (!lvl && model_live() && m_rise > 0) begin
            m_fall++;
            if (m_fall == 8) begin
                m_strb = 1'b1;
                m_res  = result_i;
            end else if (m_fall == 9) begin
                m_strb = 1'b0;
                m_pwr  = m_pd;               // R7 applied at conversion end
                m_sdo  = m_res[11];
            end else if (m_fall >= 10 && m_fall <= 20) begin
                m_sdo = m_res[20 - m_fall];
            end else if (m_fall == 21) begin
                m_sdo  = 1'b0;               // R4
                m_rise = 0;
            end
        end
        settle_and_compare();
        @(negedge clk);
    endtask

    task automatic set_cs(input logic v);
        @(negedge clk);
        cs_n = v;
        if (v) model_abort();                // R11
        settle_and_compare();
    endtask

    task automatic set_shdn(input logic v);
        @(negedge clk);
        shdn_n = v;
        if (!v) begin                        // R9
            model_abort();
            m_pwr = 2'b11;
        end
        settle_and_compare();
    endtask

    // abort_at: rising-edge index (1-based, including leading zeros) after which
    // the frame is aborted; kind 0 = chip-select, 1 = shutdown; 0 = no abort
    task automatic frame(input logic [6:0] ctl, input logic [11:0] res, input int nz,
                         input int abort_at, input int kind);
        result_i = res;
        set_cs(1'b0);
        for (int c = 1; c <= nz + 24; c++) begin
            logic b;
            if (c <= nz) b = 1'b0;
            else if (c == nz + 1) b = 1'b1;
            else if (c <= nz + 8) b = ctl[6 - (c - nz - 2)];
            else b = 1'b0;
            sedge(1'b1, b);
            if (c == abort_at) begin
                if (kind == 0) begin
                    set_cs(1'b1);
                end else begin
                    set_shdn(1'b0);
                    for (int k = 0; k < 3; k++) begin   // R9 start bits ignored in shutdown
                        sedge(1'b1, 1'b1);
                        sedge(1'b0, 1'b1);
                    end
                    set_shdn(1'b1);
                    set_cs(1'b1);
                end
                sedge(1'b0, 1'b0);
                return;
            end
            sedge(1'b0, 1'b0);
        end
        set_cs(1'b1);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare();                                  // R10 reset state
        // R10: start bit before settling is ignored
        set_cs(1'b0);
        sedge(1'b1, 1'b1);
        sedge(1'b0, 1'b0);
        set_cs(1'b1);
        repeat (SETTLE + 5) @(negedge clk);
        m_ready = 1'b1;
        compare();
        // R1 R2 R3 R6: plain frame, full power kept
        frame(7'b101_1_0_11, 12'hA5C, 0, 0, 0);
        // R1: leading zeros ignored; R7 standby mode 10
        frame(7'b011_0_1_10, 12'h3F1, 3, 0, 0);
        // R8: start bit in standby returns to full power, then mode 01
        frame(7'b110_1_1_01, 12'h800, 1, 0, 0);
        // R7: full power-down, sub-LSB bits exercised
        frame(7'b000_0_0_00, 12'h003, 0, 0, 0);
        // R8: wake from power-down
        frame(7'b111_1_1_11, 12'hFFF, 2, 0, 0);
        // R9: shutdown after the control word, before conversion end; power-down not applied
        frame(7'b010_1_0_00, 12'h555, 0, 8, 1);
        // R11: chip-select raised during result transfer keeps fields and power
        frame(7'b100_0_1_10, 12'hC3A, 0, 12, 0);
        // R11: chip-select raised mid control word, fields unchanged
        frame(7'b001_1_1_01, 12'h0F0, 0, 4, 0);
        // R4: recovery frame
        frame(7'b011_1_0_11, 12'h6D2, 1, 0, 0);
        done = 1'b1;
        finish_run();
    end

endmodule